// File: doc/BRIEF.md
# Shadowed Compare Value Update Controller

This block keeps two compare values, channel A and channel B, for a PWM timer. Software writes a new value into a channel's shadow register. The comparator reads the channel's active register, which this block drives out. A 4-bit update-method field per channel, held in a configuration word, decides when the shadow value moves into the active register:

- at once, when the field is zero;
- on a timer zero event;
- on a timer period event;
- on an external sync pulse;
- never, while the disable bit is set.

A read-only pending flag per channel shows that a written value is still waiting to be copied.

Software reaches the block through a single-cycle write strobe with an address and a data word, and through a registered read port. The timer supplies its events as one-cycle pulses in the block's clock domain. The two active values are register outputs. The block has three registers:

- address 0: the configuration word;
- address 1: the shadow register of channel A;
- address 2: the shadow register of channel B.

Top module: `shadow_cmp_update`

## Requirements
- R1: After reset, both active outputs are zero, and the configuration word at address 0 reads as zero: immediate mode on both channels, with no pending flag set.
- R2: When a channel's method field is 0, a shadow write appears on that channel's active output at the clock edge that takes the write. The pending flag stays clear.
- R3: When method bit 0 is set, a pending value is copied to the active output at the edge where the zero event is high.
- R4: When method bit 1 is set, a pending value is copied at the edge where the period event is high. Events whose bits are clear in the method field have no effect on the channel.
- R5: When method bit 2 is set, a pending value is copied at the edge where the sync input is high. When more than one event bit is set, the first enabled event to arrive triggers the copy.
- R6: While method bit 3 is set, the active output never changes, whatever the other method bits and events are. A written value stays pending.
- R7: The configuration word has this layout: bits 3:0 are the method field of channel A, bits 7:4 are the method field of channel B, bit 8 is the pending flag of A and bit 9 is the pending flag of B. A pending flag is set by a shadow write that is not copied in the same cycle, and cleared by the copy. A read returns the register selected by rd_addr one cycle later.
- R8: Software writes to bits 9:8 of the configuration word do not change the pending flags.
- R9: When a shadow write and an enabled event fall in the same cycle, the newly written value becomes active at that edge, and the pending flag ends the cycle clear.
- R10: An enabled event that arrives while nothing is pending leaves the active output unchanged.
- R11: When a channel's method field is changed to 0 while a value is pending, that value becomes active one edge after the configuration write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_addr | input | AW | Write address: 0 configuration, 1 shadow A, 2 shadow B |
| wr_data | input | DW | Write data |
| rd_addr | input | AW | Read address, same map as the write address |
| rd_data | output | DW | Registered read data, valid one cycle after rd_addr |
| ev_zero | input | 1 | Timer-reached-zero pulse |
| ev_period | input | 1 | Timer-reached-period pulse |
| ev_sync | input | 1 | External sync pulse |
| act_a | output | CW | Active compare value of channel A |
| act_b | output | CW | Active compare value of channel B |

## Verification
Every copy into an active register, and every change of a pending flag, takes effect at the same clock edge that samples the write or event. The bench therefore drives each step on a falling edge and compares the active outputs at the next falling edge, after exactly one rising edge. The read port adds one register stage. Each status check is made after an idle cycle, in which no write and no event can change the state, so the value read reflects the step before it. For a switch to immediate mode, the pending value is expected one cycle after the configuration write. The cycle between the two is checked as well.

// File: rtl/shadow_cmp_pkg.sv
package shadow_cmp_pkg;
  localparam int NUM_CH   = 2;
  localparam int MODE_W   = 4;
  localparam int PEND_LSB = NUM_CH * MODE_W;

  localparam int ADDR_CFG = 0;
  localparam int ADDR_SHA = 1;
  localparam int ADDR_SHB = 2;

  typedef logic [MODE_W-1:0] upd_mode_t;

  localparam int MB_ZERO   = 0;
  localparam int MB_PERIOD = 1;
  localparam int MB_SYNC   = 2;
  localparam int MB_HOLD   = 3;

  function automatic logic mode_fires(input upd_mode_t m, input logic z,
                                      input logic p, input logic s);
    logic hit;
    hit = (m[MB_ZERO] & z) | (m[MB_PERIOD] & p) | (m[MB_SYNC] & s);
    return !m[MB_HOLD] && ((m == '0) || hit);
  endfunction
endpackage

// File: rtl/upd_cfg_regs.sv
module upd_cfg_regs
  import shadow_cmp_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      cfg_we,
  input  logic [DW-1:0] cfg_wdata,
  output upd_mode_t mode [NUM_CH]
);
  for (genvar i = 0; i < NUM_CH; i++) begin : g_mode
    upd_mode_t mode_q;
    always_ff @(posedge clk) begin
      if (rst)         mode_q <= '0;
      else if (cfg_we) mode_q <= cfg_wdata[i*MODE_W +: MODE_W];
    end
    assign mode[i] = mode_q;
  end
endmodule

// File: rtl/upd_channel.sv
module upd_channel
  import shadow_cmp_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          shd_we,
  input  logic [CW-1:0] shd_wdata,
  input  upd_mode_t     mode,
  input  logic          ev_zero,
  input  logic          ev_period,
  input  logic          ev_sync,
  output logic [CW-1:0] shadow,
  output logic [CW-1:0] active,
  output logic          pending
);
  logic fire;

  always_comb fire = mode_fires(mode, ev_zero, ev_period, ev_sync);

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow  <= '0;
      active  <= '0;
      pending <= 1'b0;
    end else begin
      if (shd_we) shadow <= shd_wdata;
      if (fire) begin
        if (shd_we)       active <= shd_wdata;
        else if (pending) active <= shadow;
        pending <= 1'b0;
      end else if (shd_we) begin
        pending <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/shadow_cmp_update.sv
module shadow_cmp_update
  import shadow_cmp_pkg::*;
#(
  parameter int CW = 16,
  parameter int DW = 32,
  parameter int AW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  input  logic          ev_zero,
  input  logic          ev_period,
  input  logic          ev_sync,
  output logic [CW-1:0] act_a,
  output logic [CW-1:0] act_b
);
  localparam int STAT_W = PEND_LSB + NUM_CH;

  upd_mode_t         mode   [NUM_CH];
  logic [CW-1:0]     shd    [NUM_CH];
  logic [CW-1:0]     act    [NUM_CH];
  logic [NUM_CH-1:0] pend;
  logic              cfg_we;
  logic [STAT_W-1:0] stat_word;
  logic [DW-1:0]     rd_next;

  upd_mode_t mode_a, mode_b;
  logic      pend_a, pend_b;

  assign cfg_we = wr_en && (wr_addr == AW'(ADDR_CFG));

  upd_cfg_regs #(.DW(DW)) cfg_i (
    .clk      (clk),
    .rst      (rst),
    .cfg_we   (cfg_we),
    .cfg_wdata(wr_data),
    .mode     (mode)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic sel;
    assign sel = wr_en && (wr_addr == AW'(ADDR_SHA + i));
    upd_channel #(.CW(CW)) ch_i (
      .clk      (clk),
      .rst      (rst),
      .shd_we   (sel),
      .shd_wdata(wr_data[CW-1:0]),
      .mode     (mode[i]),
      .ev_zero  (ev_zero),
      .ev_period(ev_period),
      .ev_sync  (ev_sync),
      .shadow   (shd[i]),
      .active   (act[i]),
      .pending  (pend[i])
    );
    assign stat_word[i*MODE_W +: MODE_W] = mode[i];
  end
  assign stat_word[STAT_W-1:PEND_LSB] = pend;

  assign act_a  = act[0];
  assign act_b  = act[1];
  assign mode_a = mode[0];
  assign mode_b = mode[1];
  assign pend_a = pend[0];
  assign pend_b = pend[1];

  always_comb begin
    rd_next = '0;
    case (rd_addr)
      AW'(ADDR_CFG): rd_next = DW'(stat_word);
      AW'(ADDR_SHA): rd_next = DW'(shd[0]);
      AW'(ADDR_SHB): rd_next = DW'(shd[1]);
      default:       rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_next;
  end
endmodule

// File: rtl/shadow_cmp_update_chk.sv
module shadow_cmp_update_chk
  import shadow_cmp_pkg::*;
#(
  parameter int CW = 16,
  parameter int DW = 32,
  parameter int AW = 2
) (
  input logic          clk,
  input logic          rst,
  input logic          wr_en,
  input logic [AW-1:0] wr_addr,
  input logic [DW-1:0] wr_data,
  input logic          ev_zero,
  input logic [CW-1:0] act_a,
  input logic [CW-1:0] act_b,
  input upd_mode_t     mode_a,
  input upd_mode_t     mode_b,
  input logic          pend_a,
  input logic          pend_b
);
  logic wa, wb;
  assign wa = wr_en && (wr_addr == AW'(ADDR_SHA));
  assign wb = wr_en && (wr_addr == AW'(ADDR_SHB));

  // R2
  imm_copy_chk: assert property (@(posedge clk) disable iff (rst)
    (wa && mode_a == '0) |=> (act_a == $past(wr_data[CW-1:0]) && !pend_a));

  // R6
  hold_a_chk: assert property (@(posedge clk) disable iff (rst)
    mode_a[MB_HOLD] |=> $stable(act_a));

  // R6
  hold_b_chk: assert property (@(posedge clk) disable iff (rst)
    mode_b[MB_HOLD] |=> $stable(act_b));

  // R7
  imm_no_pend_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_b == '0) |=> !pend_b);

  // R9
  same_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    (wa && mode_a == 4'b0001 && ev_zero) |=> (act_a == $past(wr_data[CW-1:0]) && !pend_a));

  // R10
  idle_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (!wb && !pend_b) |=> $stable(act_b));
endmodule

bind shadow_cmp_update shadow_cmp_update_chk #(.CW(CW), .DW(DW), .AW(AW)) chk_i (
  .clk    (clk),
  .rst    (rst),
  .wr_en  (wr_en),
  .wr_addr(wr_addr),
  .wr_data(wr_data),
  .ev_zero(ev_zero),
  .act_a  (act_a),
  .act_b  (act_b),
  .mode_a (mode_a),
  .mode_b (mode_b),
  .pend_a (pend_a),
  .pend_b (pend_b)
);

// File: tb/shadow_cmp_update_tb_top.sv
module shadow_cmp_update_tb_top;
  localparam int CW = 16;
  localparam int DW = 32;
  localparam int AW = 2;
  localparam int NV = 17;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [AW-1:0] rd_addr = '0;
  logic [DW-1:0] rd_data;
  logic          ev_zero = 1'b0, ev_period = 1'b0, ev_sync = 1'b0;
  logic [CW-1:0] act_a, act_b;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  shadow_cmp_update #(.CW(CW), .DW(DW), .AW(AW)) dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .ev_zero(ev_zero), .ev_period(ev_period),
    .ev_sync(ev_sync), .act_a(act_a), .act_b(act_b)
  );

  // Entry layout: {we, addr[1:0], data[31:0], ev{sync,period,zero}, exp_a[15:0], exp_b[15:0]}
  localparam logic [69:0] TBL [NV] = '{
    {1'b1, 2'd1, 32'h0000_0011, 3'b000, 16'h0011, 16'h0000}, // R2 immediate on A
    {1'b1, 2'd2, 32'h0000_0022, 3'b000, 16'h0011, 16'h0022}, // R2 immediate on B
    {1'b1, 2'd0, 32'h0000_0021, 3'b000, 16'h0011, 16'h0022}, // A zero, B period
    {1'b1, 2'd1, 32'h0000_0100, 3'b000, 16'h0011, 16'h0022}, // R3 A waits
    {1'b0, 2'd0, 32'h0000_0000, 3'b010, 16'h0011, 16'h0022}, // R4 period ignored by A
    {1'b0, 2'd0, 32'h0000_0000, 3'b001, 16'h0100, 16'h0022}, // R3 zero copies A
    {1'b1, 2'd2, 32'h0000_0200, 3'b001, 16'h0100, 16'h0022}, // R4 B waits, R10 A idle
    {1'b0, 2'd0, 32'h0000_0000, 3'b010, 16'h0100, 16'h0200}, // R4 period copies B
    {1'b1, 2'd1, 32'h0000_0300, 3'b001, 16'h0300, 16'h0200}, // R9 write plus zero
    {1'b1, 2'd0, 32'h0000_0084, 3'b000, 16'h0300, 16'h0200}, // A sync, B hold
    {1'b1, 2'd2, 32'h0000_0400, 3'b000, 16'h0300, 16'h0200}, // R6 B held
    {1'b0, 2'd0, 32'h0000_0000, 3'b111, 16'h0300, 16'h0200}, // R6 R10 all events
    {1'b1, 2'd1, 32'h0000_0500, 3'b000, 16'h0300, 16'h0200}, // R5 A waits
    {1'b0, 2'd0, 32'h0000_0000, 3'b100, 16'h0500, 16'h0200}, // R5 sync copies A
    {1'b1, 2'd0, 32'h0000_000C, 3'b000, 16'h0500, 16'h0200}, // R11 B to immediate
    {1'b0, 2'd0, 32'h0000_0000, 3'b000, 16'h0500, 16'h0400}, // R11 B copies next edge
    {1'b1, 2'd1, 32'h0000_0600, 3'b111, 16'h0500, 16'h0400}  // R6 hold overrides bits
  };

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic we, input logic [AW-1:0] a, input logic [DW-1:0] d,
                      input logic [2:0] ev);
    wr_en = we; wr_addr = a; wr_data = d;
    {ev_sync, ev_period, ev_zero} = ev;
    @(negedge clk);
    wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    {ev_sync, ev_period, ev_zero} = 3'b000;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1 act_a", DW'(act_a), 0);
    check("R1 act_b", DW'(act_b), 0);
    step(1'b0, '0, '0, 3'b000);
    check("R1 config word", rd_data, 0);

    for (int i = 0; i < NV; i++) begin
      logic [69:0] v;
      v = TBL[i];
      step(v[69], v[68:67], v[66:35], v[34:32]);
      check($sformatf("vector %0d A (R2,R3,R4,R5,R6,R9,R10,R11)", i), DW'(act_a), DW'(v[31:16]));
      check($sformatf("vector %0d B (R2,R3,R4,R5,R6,R9,R10,R11)", i), DW'(act_b), DW'(v[15:0]));
    end

    // R7 status: A pending (bit 8), B clear, modes A=C, B=0
    step(1'b0, '0, '0, 3'b000);
    check("R7 status read", rd_data, 32'h0000_010C);
    // R8 writing ones to status bits sets nothing
    step(1'b1, 2'd0, 32'h0000_030C, 3'b000);
    step(1'b0, '0, '0, 3'b000);
    check("R8 status ones ignored", rd_data, 32'h0000_010C);
    // R8 writing zeros to status bits clears nothing
    step(1'b1, 2'd0, 32'h0000_000C, 3'b000);
    step(1'b0, '0, '0, 3'b000);
    check("R8 status zeros ignored", rd_data, 32'h0000_010C);
    // R11 A switched to immediate with a pending value
    step(1'b1, 2'd0, 32'h0000_0000, 3'b000);
    check("R11 A still old at cfg edge", DW'(act_a), 32'h0000_0500);
    step(1'b0, '0, '0, 3'b000);
    check("R11 A copied next edge", DW'(act_a), 32'h0000_0600);
    step(1'b0, '0, '0, 3'b000);
    check("R7 pending cleared after copy", rd_data, 32'h0000_0000);
    // R7 shadow readback
    rd_addr = 2'd1;
    step(1'b0, '0, '0, 3'b000);
    check("R7 shadow A read", rd_data, 32'h0000_0600);
    rd_addr = 2'd0;
    // R1 reset mid-run
    step(1'b1, 2'd0, 32'h0000_0011, 3'b000);
    step(1'b1, 2'd1, 32'h0000_0777, 3'b000);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R1 act_a after reset", DW'(act_a), 0);
    check("R1 act_b after reset", DW'(act_b), 0);
    step(1'b0, '0, '0, 3'b000);
    check("R1 config after reset", rd_data, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule